// File: doc/BRIEF.md
# Logical Right Shifter with Flags

This block performs an unsigned right shift on an operand of 8, 16, 32 or 64 bits and produces the updated arithmetic flags. Zeros fill the vacated high positions, so the result is the operand divided by two to the power of the count. The count arrives as a raw 8-bit value. The block reduces it to a count field whose width depends on the operand size class, not on the operand width.

The flags form a 5-bit vector: bit 0 carry, bit 1 parity, bit 2 zero, bit 3 sign, bit 4 overflow. The block outputs the new flag vector and a write-enable vector with the same bit layout. A zero count leaves every flag alone. Any other count rewrites all five flags. With `REG_OUT` = 1 (the default), all outputs are registered and appear one clock after the inputs. With `REG_OUT` = 0, the outputs are combinational.

Top module: `shr_flag_unit`

## Requirements
- R1: `result_o` equals the operand, truncated to the selected size, shifted right by the masked count, with zeros entering at the top.
- R2: The size code on `size_i` is 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Codes 0 to 2 use `count_i[4:0]` as the masked count. Code 3 uses `count_i[5:0]`. Higher count bits have no effect on any output.
- R3: For 8- or 16-bit operands, a masked count equal to or greater than the width gives a zero result and a carry (bit 0) of 0.
- R4: For a nonzero masked count below the width, carry (bit 0) is operand bit (count-1), which is the last bit shifted out.
- R5: Overflow (bit 4) equals the operand's top bit at the selected size when the masked count is 1. It is 0 when the masked count is greater than 1.
- R6: For a masked count of 0, the result equals the size-truncated operand, `flags_o` equals `flags_i`, and `flag_we_o` is 5'b00000.
- R7: For a nonzero masked count, `flag_we_o` is 5'b11111.
- R8: For a nonzero masked count, sign (bit 3) is the result's top bit at the selected size. Zero (bit 2) is 1 exactly when the result is all zeros. Parity (bit 1) is 1 when `result_o[7:0]` holds an even number of ones.
- R9: Result bits above the selected size are always 0.
- R10: With `REG_OUT` = 1, outputs follow the inputs by one clock. While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| size_i | input | 2 | Operand size code |
| operand_i | input | 64 | Operand (bits above size ignored) |
| count_i | input | 8 | Raw shift count |
| flags_i | input | 5 | Incoming flags {of, sf, zf, pf, cf} |
| result_o | output | 64 | Shifted result |
| flags_o | output | 5 | Outgoing flags {of, sf, zf, pf, cf} |
| flag_we_o | output | 5 | Per-flag write enable, same layout |

## Verification
Every cycle, the assertions check the following structural invariants:
- The write-enable vector is either all ones or all zeros.
- The sign flag is clear after a real shift.
- Zero and parity agree with the result.
- The high bits above the selected size stay clear.
- A zero count passes the flags through.
- The over-width case gives a zero result and carry.
- Overflow is clear on multi-bit shifts.

Two behaviours depend on the actual data, and only the bench's sweep of every size, every raw count and several operand and flag patterns can show them. One is the exact shifted value. The other is which bit becomes the carry. The same sweep also shows that high count bits are ignored.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int DATA_W  = 64;
  localparam int CNT_W   = 8;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int FLAG_W  = 5;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} size_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } flags_t;

  function automatic logic [SHAMT_W:0] size_width(input size_e sz);
    return (SHAMT_W + 1)'(8) << sz;
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input size_e sz);
    return {DATA_W{1'b1}} >> (DATA_W - int'(size_width(sz)));
  endfunction

  function automatic logic msb_at(input logic [DATA_W-1:0] v, input size_e sz);
    case (sz)
      SZ_8:    return v[7];
      SZ_16:   return v[15];
      SZ_32:   return v[31];
      default: return v[DATA_W-1];
    endcase
  endfunction
endpackage

// File: rtl/shr_count_mask.sv
module shr_count_mask
  import shr_pkg::*;
(
  input  size_e              size_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic [SHAMT_W-1:0] amt_o,
  output logic               amt_zero_o,
  output logic               amt_one_o,
  output logic               over_width_o
);
  localparam int NARROW_W = SHAMT_W - 1;

  always_comb begin
    if (size_i == SZ_64) amt_o = count_i[SHAMT_W-1:0];
    else                 amt_o = {1'b0, count_i[NARROW_W-1:0]};
  end

  assign amt_zero_o   = (amt_o == '0);
  assign amt_one_o    = (amt_o == SHAMT_W'(1));
  assign over_width_o = !amt_zero_o && ({1'b0, amt_o} >= size_width(size_i));
endmodule

// File: rtl/shr_shift_core.sv
module shr_shift_core
  import shr_pkg::*;
(
  input  size_e              size_i,
  input  logic [DATA_W-1:0]  operand_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               over_width_i,
  output logic [DATA_W-1:0]  op_sized_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               carry_o
);
  // stage vector carries one guard bit below the operand to catch the last bit out
  logic [DATA_W:0] stage [SHAMT_W+1];

  assign op_sized_o = operand_i & size_mask(size_i);
  assign stage[0]   = {op_sized_o, 1'b0};

  for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
    assign stage[i+1] = amt_i[i] ? (stage[i] >> (1 << i)) : stage[i];
  end

  assign result_o = over_width_i ? '0 : stage[SHAMT_W][DATA_W:1];
  assign carry_o  = over_width_i ? 1'b0 : stage[SHAMT_W][0];
endmodule

// File: rtl/shr_flag_gen.sv
module shr_flag_gen
  import shr_pkg::*;
(
  input  size_e             size_i,
  input  flags_t            flags_i,
  input  logic [DATA_W-1:0] op_sized_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              amt_zero_i,
  input  logic              amt_one_i,
  output flags_t            flags_o,
  output logic [FLAG_W-1:0] we_o
);
  always_comb begin
    if (amt_zero_i) begin
      flags_o = flags_i;
      we_o    = '0;
    end else begin
      flags_o.cf = carry_i;
      flags_o.pf = ~^result_i[7:0];
      flags_o.zf = (result_i == '0);
      flags_o.sf = msb_at(result_i, size_i);
      flags_o.of = amt_one_i & msb_at(op_sized_i, size_i);
      we_o       = '1;
    end
  end
endmodule

// File: rtl/shr_flag_unit.sv
module shr_flag_unit
  import shr_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        size_i,
  input  logic [63:0]       operand_i,
  input  logic [7:0]        count_i,
  input  logic [4:0]        flags_i,
  output logic [63:0]       result_o,
  output logic [4:0]        flags_o,
  output logic [4:0]        flag_we_o
);
  size_e              size;
  logic [SHAMT_W-1:0] amt;
  logic               amt_zero, amt_one, over_width;
  logic [DATA_W-1:0]  op_sized, result_c;
  logic               carry_c;
  flags_t             flags_c;
  logic [FLAG_W-1:0]  we_c;

  assign size = size_e'(size_i);

  shr_count_mask u_mask (
    .size_i(size), .count_i(count_i), .amt_o(amt),
    .amt_zero_o(amt_zero), .amt_one_o(amt_one), .over_width_o(over_width)
  );

  shr_shift_core u_core (
    .size_i(size), .operand_i(operand_i), .amt_i(amt), .over_width_i(over_width),
    .op_sized_o(op_sized), .result_o(result_c), .carry_o(carry_c)
  );

  shr_flag_gen u_flags (
    .size_i(size), .flags_i(flags_t'(flags_i)), .op_sized_i(op_sized),
    .result_i(result_c), .carry_i(carry_c), .amt_zero_i(amt_zero),
    .amt_one_i(amt_one), .flags_o(flags_c), .we_o(we_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o  <= '0;
        flags_o   <= '0;
        flag_we_o <= '0;
      end else begin
        result_o  <= result_c;
        flags_o   <= flags_c;
        flag_we_o <= we_c;
      end
    end
  end else begin : g_comb
    assign result_o  = result_c;
    assign flags_o   = flags_c;
    assign flag_we_o = we_c;
  end

  AST_WE_ALL_OR_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_o == '0) || (flag_we_o == '1)); // R7
  AST_ZERO_CNT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amt_zero |-> (flags_c == flags_t'(flags_i)) && (we_c == '0) && (result_c == op_sized)); // R6
  AST_OVER_WIDTH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_width |-> (result_c == '0) && !flags_c.cf); // R3
  AST_OF_MULTI_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!amt_zero && !amt_one) |-> !flags_c.of); // R5
  AST_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_c & ~size_mask(size)) == '0); // R9
  AST_SIGN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_o != '0) |-> !flags_o[3]); // R8
  AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_o != '0) |-> (flags_o[2] == (result_o == '0))); // R8
  AST_PARITY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_o != '0) |-> (flags_o[1] == ~^result_o[7:0])); // R8
endmodule

// File: tb/shr_flag_unit_tb.sv
`timescale 1ns/1ps
module shr_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size = '0;
  logic [63:0] operand = '0;
  logic [7:0]  count = '0;
  logic [4:0]  flags_in = '0;
  logic [63:0] result;
  logic [4:0]  flags_out, flag_we;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  shr_flag_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .size_i(size), .operand_i(operand),
    .count_i(count), .flags_i(flags_in), .result_o(result),
    .flags_o(flags_out), .flag_we_o(flag_we)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s size=%0d cnt=%0d op=%h: actual=%h expected=%h",
               req, size, count, operand, act, exp);
    end
  endtask

  task automatic apply(input int sz, input logic [63:0] op, input int cnt, input logic [4:0] fin);
    int          width, m;
    longint unsigned opz, exp_res;
    logic [4:0]  exp_fl, exp_we;
    @(negedge clk);
    size = 2'(sz); operand = op; count = 8'(cnt); flags_in = fin;
    width = 8 << sz;
    m   = (sz == 3) ? (cnt % 64) : (cnt % 32);
    opz = (width == 64) ? op : (op & ((64'd1 << width) - 1));
    if (m == 0) begin
      exp_res = opz; exp_fl = fin; exp_we = 5'b00000;
    end else begin
      exp_res = (m >= width) ? 64'd0 : (opz >> m);
      exp_we  = 5'b11111;
      exp_fl[0] = (m >= width) ? 1'b0 : opz[m-1];
      exp_fl[1] = ($countones(exp_res[7:0]) % 2) == 0;
      exp_fl[2] = (exp_res == 0);
      exp_fl[3] = exp_res[width-1];
      exp_fl[4] = (m == 1) ? opz[width-1] : 1'b0;
    end
    @(posedge clk); #1;
    if (m == 0)            check("R6 result", result, exp_res);
    else if (m >= width)   check("R3 result", result, exp_res);
    else if (cnt != m)     check("R2 result", result, exp_res);
    else                   check("R1 result", result, exp_res);
    check("R9 upper", result & ~((width == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << width) - 1)), 64'd0);
    check(m == 0 ? "R6 we" : "R7 we", 64'(flag_we), 64'(exp_we));
    check(m == 0 ? "R6 flags" : (m >= width ? "R3 carry" : "R4 carry"), 64'(flags_out[0]), 64'(exp_fl[0]));
    check("R8 pf/zf/sf", 64'(flags_out[3:1]), 64'(exp_fl[3:1]));
    check("R5 of", 64'(flags_out[4]), 64'(exp_fl[4]));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [4];
    pats[0] = 64'hF0F0_A5A5_8000_0081;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h8000_0000_8000_8080;
    pats[3] = 64'h0123_4567_89AB_CDEF;
    #7;
    check("R10 reset result", result, 64'd0);
    check("R10 reset flags", 64'({flags_out, flag_we}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int sz = 0; sz < 4; sz++)
      for (int p = 0; p < 4; p++)
        for (int c = 0; c < 256; c++)
          apply(sz, pats[p], c, 5'((c * 7 + p) % 32));
    apply(0, 64'h0, 1, 5'b11111);
    apply(2, 64'h0000_0000_0000_0001, 1, 5'b00000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule